// File: doc/BRIEF.md
# Lost-Sample Gap Tagger

The gap tagger sits between a continuous stream of ADC samples and the write port of an acquisition FIFO. Each sample is 14 bits wide and carries a 4-bit channel number. It is written as a 16-bit word whose two upper bits act as a word-type tag. When the FIFO has no free slot, an arriving sample cannot be stored. The block drops it, adds one to a 38-bit lost-sample counter and keeps the channel number of that sample.

Once the FIFO reports at least three free slots, the block writes three tagged error words in consecutive cycles, and only then lets sample data through again. Together the error words carry the full drop count and the channel of the last dropped sample. Downstream software can therefore see where the gap is, how many samples are missing, and which channel the first sample after the gap belongs to.

The count and channel are frozen into a report snapshot in the cycle the error sequence starts. Samples that arrive while the error words are being written are also lost. They are counted again from zero and reported by a further error sequence that follows straight after.

Top module: `gap_tagger`

## Requirements
- R1: In normal operation, a valid sample with `fifo_space` nonzero is written in the same cycle as `{2'b00, sample}`.
- R2: A valid sample that arrives while `fifo_space` is zero, or while a gap is pending or being reported, is not written as data.
- R3: `out_wr` is never high while `fifo_space` is zero.
- R4: The error sequence starts only after a cycle in which a gap is pending and `fifo_space` is at least 3. The three error words follow in the next three consecutive cycles, tagged 01, 10 and 11 in bits 15:14.
- R5: The first error word holds lost-count bits 37..24 in bits 13:0.
- R6: The second error word holds lost-count bits 23..10 in bits 13:0.
- R7: The third error word holds lost-count bits 9..0 in bits 13:4 and the channel of the last dropped sample in bits 3:0.
- R8: No data word is written from the first dropped sample until the third error word has been written, even when 1 or 2 slots are free.
- R9: The reported count includes the sample that arrives in the cycle the sequence starts. Samples dropped during the three error words are counted afresh and reported by a further sequence, which then precedes any data.
- R10: The lost counter saturates at its maximum value (parameter `LOST_MAX`, all ones by default) instead of wrapping.
- R11: After reset the block is in normal operation with a zero count, and it writes nothing until a valid sample arrives.
- R12: With `in_valid` low in normal operation, nothing is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is presented this cycle |
| in_sample | input | 14 | Sample value |
| in_chan | input | 4 | Channel number of the sample |
| fifo_space | input | SPACE_W | Free slots in the FIFO this cycle |
| out_wr | output | 1 | FIFO write strobe |
| out_word | output | 16 | Word to write: tag in 15:14, payload in 13:0 |

## Verification
Plain samples are passed through with extreme and alternating bit patterns at exactly one free slot. This separates a correct full test from an off-by-one on the free count. One gap of five drops is held with two free slots, which shows that the sequence waits for room for all three words. A gap of 1500 drops carries into lost-count bit 10 and exposes a misplaced split between the second and third error words. The same stimulus, applied to a second instance with a small saturation limit, shows clamping instead of wrap-around. A final gap with drops both in the start cycle and during the error words checks the count snapshot and the follow-up sequence that reports the backlog.

// File: rtl/gap_tag_pkg.sv
package gap_tag_pkg;

  localparam int DATA_W    = 14;
  localparam int TAG_W     = 2;
  localparam int WORD_W    = DATA_W + TAG_W;
  localparam int CHAN_W    = 4;
  localparam int CNT_W     = 38;
  localparam int ERR_WORDS = 3;
  localparam int IDX_W     = 2;

  // Field split of the lost count across the three error words
  localparam int HI_LSB  = 24;
  localparam int MID_LSB = 10;

  localparam logic [TAG_W-1:0] TAG_DATA = 2'b00;
  localparam logic [TAG_W-1:0] TAG_E1   = 2'b01;
  localparam logic [TAG_W-1:0] TAG_E2   = 2'b10;
  localparam logic [TAG_W-1:0] TAG_E3   = 2'b11;

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ERR_WORDS - 1);

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_DROP   = 2'd1,
    ST_EMIT   = 2'd2
  } gt_state_e;

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [CHAN_W-1:0] chan;
  } gt_report_t;

  function automatic logic [WORD_W-1:0] pack_data(input logic [DATA_W-1:0] s);
    return {TAG_DATA, s};
  endfunction

  function automatic logic [WORD_W-1:0] pack_err(input logic [IDX_W-1:0] idx,
                                                  input gt_report_t rep);
    logic [WORD_W-1:0] w;
    case (idx)
      2'd0:    w = {TAG_E1, rep.cnt[CNT_W-1:HI_LSB]};
      2'd1:    w = {TAG_E2, rep.cnt[HI_LSB-1:MID_LSB]};
      default: w = {TAG_E3, rep.cnt[MID_LSB-1:0], rep.chan};
    endcase
    return w;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] n,
                                                input logic [CNT_W-1:0] lim);
    return (n >= lim) ? lim : n + CNT_W'(1);
  endfunction

endpackage

// File: rtl/gt_loss_counter.sv
module gt_loss_counter
  import gap_tag_pkg::*;
#(
  parameter logic [CNT_W-1:0] LIMIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_upd
);

  always_comb begin
    cnt_upd = inc ? sat_inc(cnt, LIMIT) : cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else           cnt <= cnt_upd;
  end

endmodule

// File: rtl/gt_ctrl.sv
module gt_ctrl
  import gap_tag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             fifo_full,
  input  logic             fifo_room,
  input  logic             backlog,
  output gt_state_e        state,
  output logic [IDX_W-1:0] idx,
  output logic             ev_drop,
  output logic             ev_start,
  output logic             ev_done
);

  always_comb begin
    ev_drop  = in_valid && ((state != ST_NORMAL) || fifo_full);
    ev_start = (state == ST_DROP) && fifo_room;
    ev_done  = (state == ST_EMIT) && (idx == IDX_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_NORMAL;
      idx   <= '0;
    end else begin
      case (state)
        ST_NORMAL: if (ev_drop) state <= ST_DROP;
        ST_DROP: if (ev_start) begin
          state <= ST_EMIT;
          idx   <= '0;
        end
        ST_EMIT: if (ev_done) begin
          state <= backlog ? ST_DROP : ST_NORMAL;
          idx   <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
        default: begin
          state <= ST_NORMAL;
          idx   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/gt_word_mux.sv
module gt_word_mux
  import gap_tag_pkg::*;
(
  input  gt_state_e         state,
  input  logic [IDX_W-1:0]  idx,
  input  logic              in_valid,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] in_sample,
  input  gt_report_t        rep,
  output logic              out_wr,
  output logic [WORD_W-1:0] out_word
);

  always_comb begin
    out_wr   = 1'b0;
    out_word = '0;
    case (state)
      ST_NORMAL: begin
        out_wr   = in_valid && !fifo_full;
        out_word = pack_data(in_sample);
      end
      ST_EMIT: begin
        out_wr   = 1'b1;
        out_word = pack_err(idx, rep);
      end
      default: begin
        out_wr   = 1'b0;
        out_word = '0;
      end
    endcase
  end

endmodule

// File: rtl/gap_tagger.sv
module gap_tagger
  import gap_tag_pkg::*;
#(
  parameter int               SPACE_W  = 15,
  parameter logic [CNT_W-1:0] LOST_MAX = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_sample,
  input  logic [CHAN_W-1:0]  in_chan,
  input  logic [SPACE_W-1:0] fifo_space,
  output logic               out_wr,
  output logic [WORD_W-1:0]  out_word
);

  localparam logic [SPACE_W-1:0] ROOM_NEED = SPACE_W'(ERR_WORDS);

  // Named internal events, also observed by the checker
  logic             fifo_full;
  logic             fifo_room;
  logic             ev_drop;
  logic             ev_start;
  logic             ev_done;
  logic             st_normal;
  logic             backlog;
  gt_state_e        state;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] live_cnt;
  logic [CNT_W-1:0] live_upd;
  logic [CHAN_W-1:0] live_chan;
  logic [CHAN_W-1:0] chan_upd;
  gt_report_t       rep;

  assign fifo_full = (fifo_space == '0);
  assign fifo_room = (fifo_space >= ROOM_NEED);
  assign st_normal = (state == ST_NORMAL);
  assign backlog   = (live_upd != '0);
  assign chan_upd  = ev_drop ? in_chan : live_chan;

  gt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .fifo_full(fifo_full),
    .fifo_room(fifo_room),
    .backlog  (backlog),
    .state    (state),
    .idx      (idx),
    .ev_drop  (ev_drop),
    .ev_start (ev_start),
    .ev_done  (ev_done)
  );

  gt_loss_counter #(.LIMIT(LOST_MAX)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (ev_drop),
    .clr    (ev_start),
    .cnt    (live_cnt),
    .cnt_upd(live_upd)
  );

  // Channel of the most recent dropped sample
  always_ff @(posedge clk) begin
    if (!rst_n) live_chan <= '0;
    else        live_chan <= chan_upd;
  end

  // Report snapshot: loaded when the sequence starts, cleared after word 3
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep <= '0;
    end else if (ev_start) begin
      rep.cnt  <= live_upd;
      rep.chan <= chan_upd;
    end else if (ev_done) begin
      rep <= '0;
    end
  end

  gt_word_mux u_mux (
    .state    (state),
    .idx      (idx),
    .in_valid (in_valid),
    .fifo_full(fifo_full),
    .in_sample(in_sample),
    .rep      (rep),
    .out_wr   (out_wr),
    .out_word (out_word)
  );

endmodule

// File: rtl/gap_tagger_chk.sv
module gap_tagger_chk
  import gap_tag_pkg::*;
#(
  parameter int SPACE_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [DATA_W-1:0]  in_sample,
  input logic [SPACE_W-1:0] fifo_space,
  input logic               out_wr,
  input logic [WORD_W-1:0]  out_word,
  input logic               st_normal,
  input logic               ev_drop,
  input logic               ev_start,
  input logic               ev_done,
  input logic [CNT_W-1:0]   live_cnt
);

  logic [TAG_W-1:0] tag;
  assign tag = out_word[WORD_W-1:DATA_W];

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_normal && in_valid && fifo_space != '0) |-> (out_wr && out_word == {TAG_DATA, in_sample}));

  p_drop_unwritten_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> !(out_wr && tag == TAG_DATA));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> (fifo_space != '0));

  p_start_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> (fifo_space >= SPACE_W'(ERR_WORDS)));

  p_first_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (out_wr && tag == TAG_E1));

  p_second_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && tag == TAG_E1) |=> (out_wr && tag == TAG_E2));

  p_third_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && tag == TAG_E2) |=> (out_wr && tag == TAG_E3));

  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> (out_wr && tag == TAG_E3));

  p_drop_counted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && !ev_start) |=> (live_cnt != '0));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_start |=> (live_cnt >= $past(live_cnt)));

endmodule

bind gap_tagger gap_tagger_chk #(.SPACE_W(SPACE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .fifo_space(fifo_space),
  .out_wr    (out_wr),
  .out_word  (out_word),
  .st_normal (st_normal),
  .ev_drop   (ev_drop),
  .ev_start  (ev_start),
  .ev_done   (ev_done),
  .live_cnt  (live_cnt)
);

// File: tb/test_gap_tagger.sv
module test_gap_tagger;

  localparam int SPACE_W = 15;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [13:0]        in_sample = '0;
  logic [3:0]         in_chan = '0;
  logic [SPACE_W-1:0] fifo_space = '0;
  logic               out_wr, sat_wr;
  logic [15:0]        out_word, sat_word;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gap_tagger #(.SPACE_W(SPACE_W)) i_gap_tagger (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .fifo_space(fifo_space), .out_wr(out_wr), .out_word(out_word)
  );

  gap_tagger #(.SPACE_W(SPACE_W), .LOST_MAX(38'd5)) i_gap_tagger_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_chan(in_chan), .fifo_space(fifo_space), .out_wr(sat_wr), .out_word(sat_word)
  );

  // Drive one cycle's inputs after the falling edge, then settle
  task automatic cyc(input logic v, input logic [13:0] s, input logic [3:0] c,
                     input int space);
    @(negedge clk);
    in_valid   = v;
    in_sample  = s;
    in_chan    = c;
    fifo_space = SPACE_W'(space);
    #1;
  endtask

  task automatic check(input string req, input logic act_wr, input logic [15:0] act_w,
                       input logic exp_wr, input logic [15:0] exp_w);
    n_run++;
    if (act_wr !== exp_wr || (exp_wr && act_w !== exp_w)) begin
      n_fail++;
      $display("FAIL %s: wr=%0b word=%h, expected wr=%0b word=%h",
               req, act_wr, act_w, exp_wr, exp_w);
    end
  endtask

  // Expected error words, restated from R5..R7
  function automatic logic [15:0] ew1(input logic [37:0] n);
    return {2'b01, n[37:24]};
  endfunction
  function automatic logic [15:0] ew2(input logic [37:0] n);
    return {2'b10, n[23:10]};
  endfunction
  function automatic logic [15:0] ew3(input logic [37:0] n, input logic [3:0] c);
    return {2'b11, n[9:0], c};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(0, 14'h0, 4'h0, 8);
    cyc(0, 14'h0, 4'h0, 8);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 14'h0, 4'h0, 8);
    check("R11 idle after reset", out_wr, out_word, 1'b0, 16'h0);
    cyc(1, 14'h0123, 4'h1, 8);
    check("R11 first sample after reset", out_wr, out_word, 1'b1, 16'h0123);
  endtask

  task automatic t_pass();
    logic [13:0] pats [4] = '{14'h0000, 14'h3FFF, 14'h2AAA, 14'h1555};
    foreach (pats[i]) begin
      cyc(1, pats[i], 4'(i), 1);
      check("R1 pass-through at one free slot", out_wr, out_word, 1'b1, {2'b00, pats[i]});
    end
    cyc(0, 14'h3FFF, 4'h2, 20);
    check("R12 no valid no write", out_wr, out_word, 1'b0, 16'h0);
  endtask

  task automatic t_small_gap();
    for (int i = 1; i <= 4; i++) begin
      cyc(1, 14'h1000, 4'(i), 0);
      check("R3 no write while full", out_wr, out_word, 1'b0, 16'h0);
    end
    cyc(1, 14'h0042, 4'h5, 2);
    check("R8 no data with two free slots", out_wr, out_word, 1'b0, 16'h0);
    cyc(0, 14'h0, 4'h0, 2);
    check("R4 no start below three free", out_wr, out_word, 1'b0, 16'h0);
    cyc(0, 14'h0, 4'h0, 3);
    check("R4 start cycle writes nothing", out_wr, out_word, 1'b0, 16'h0);
    cyc(0, 14'h0, 4'h0, 3);
    check("R5 first error word", out_wr, out_word, 1'b1, ew1(38'd5));
    cyc(0, 14'h0, 4'h0, 2);
    check("R6 second error word", out_wr, out_word, 1'b1, ew2(38'd5));
    cyc(0, 14'h0, 4'h0, 1);
    check("R7 third error word, chan 5", out_wr, out_word, 1'b1, ew3(38'd5, 4'h5));
    cyc(1, 14'h0777, 4'h6, 5);
    check("R8 data resumes after word 3", out_wr, out_word, 1'b1, 16'h0777);
  endtask

  task automatic t_long_gap();
    for (int i = 0; i < 1500; i++) cyc(1, 14'h0ABC, 4'(i % 16), 0);
    check("R2 dropped sample not written", out_wr, out_word, 1'b0, 16'h0);
    cyc(0, 14'h0, 4'h0, 3);
    cyc(0, 14'h0, 4'h0, 3);
    check("R5 count 1500 word 1", out_wr, out_word, 1'b1, ew1(38'd1500));
    check("R10 saturated word 1", sat_wr, sat_word, 1'b1, ew1(38'd5));
    cyc(0, 14'h0, 4'h0, 2);
    check("R6 count 1500 word 2", out_wr, out_word, 1'b1, ew2(38'd1500));
    check("R10 saturated word 2", sat_wr, sat_word, 1'b1, ew2(38'd5));
    cyc(0, 14'h0, 4'h0, 1);
    check("R7 count 1500 word 3, chan 11", out_wr, out_word, 1'b1, ew3(38'd1500, 4'hB));
    check("R10 saturated at 5 word 3", sat_wr, sat_word, 1'b1, ew3(38'd5, 4'hB));
  endtask

  task automatic t_overlap();
    cyc(1, 14'h0001, 4'h2, 0);
    check("R2 drop while full", out_wr, out_word, 1'b0, 16'h0);
    cyc(1, 14'h0002, 4'h3, 0);
    cyc(1, 14'h0003, 4'h4, 0);
    cyc(1, 14'h0004, 4'h6, 10);
    check("R9 sample in start cycle not written", out_wr, out_word, 1'b0, 16'h0);
    cyc(1, 14'h0005, 4'h7, 10);
    check("R9 word 1 during drop", out_wr, out_word, 1'b1, ew1(38'd4));
    cyc(0, 14'h0, 4'h0, 9);
    check("R9 word 2", out_wr, out_word, 1'b1, ew2(38'd4));
    cyc(1, 14'h0006, 4'h9, 8);
    check("R9 word 3 counts start-cycle sample", out_wr, out_word, 1'b1, ew3(38'd4, 4'h6));
    cyc(0, 14'h0, 4'h0, 7);
    check("R9 backlog start cycle", out_wr, out_word, 1'b0, 16'h0);
    cyc(0, 14'h0, 4'h0, 7);
    check("R9 backlog word 1", out_wr, out_word, 1'b1, ew1(38'd2));
    cyc(0, 14'h0, 4'h0, 6);
    check("R9 backlog word 2", out_wr, out_word, 1'b1, ew2(38'd2));
    cyc(0, 14'h0, 4'h0, 5);
    check("R9 backlog word 3, chan 9", out_wr, out_word, 1'b1, ew3(38'd2, 4'h9));
    cyc(1, 14'h2222, 4'h1, 4);
    check("R1 data after backlog report", out_wr, out_word, 1'b1, 16'h2222);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_pass();
    t_small_gap();
    t_long_gap();
    t_overlap();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

endmodule